// File: doc/BRIEF.md
# Mailbox Message Register Unit

This block is a small set of 32-bit mailbox registers shared by a local processor and a remote bus master. Each side has its own register port. The remote side fills the inbound mailboxes, and the local core is interrupted. The local core fills the outbound mailboxes, and the remote bus gets an active-low interrupt request. Each mailbox has its own sticky status bit and its own mask bit. Only the side that takes the interrupt may clear the status bit or change the mask.

Both ports share one address map and one read path. Reads are combinational, so read data is valid in the same cycle as the address. Writes take effect at the next rising clock edge. Each interrupt output comes straight from the registered status and mask bits, so it changes in the cycle after the write that caused the change.

Top module: `mbox_msg_unit`

## Requirements
- R1: After reset, both status registers and both mask registers read 0, `loc_irq` is 0 and `rem_irq_n` is 1.
- R2: A remote write to 0x050 (inbound mailbox 0) or 0x054 (inbound mailbox 1) stores the 32-bit word. Both ports read the word back from the same address.
- R3: A local write to 0x058 (outbound mailbox 0) or 0x05C (outbound mailbox 1) stores the 32-bit word. Both ports read the word back from the same address.
- R4: A mailbox write sets its status bit in the cycle after the write. Mailbox i uses bit i of the inbound status at 0x060 or bit i of the outbound status at 0x068.
- R5: Status bits are sticky. A local write to 0x060 clears each inbound status bit where the write data bit is 1. A remote write to 0x068 does the same for the outbound status bits. Data bits of 0 leave the status unchanged.
- R6: A mailbox write and a clear of the same status bit in the same cycle leave that bit set.
- R7: Only a local write changes the inbound mask at 0x064. Only a remote write changes the outbound mask at 0x06C. A mask bit of 1 blocks the interrupt of its mailbox.
- R8: `loc_irq` is high exactly when some inbound status bit is set and its mask bit is clear. `rem_irq_n` is low exactly when the same is true on the outbound side.
- R9: A write from the wrong side has no effect. This covers a local write to an inbound mailbox and a remote write to an outbound mailbox. It also covers a write to a status or mask register from the side that does not own it.
- R10: Unmapped addresses read 0. Status and mask registers read with their unused upper bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_wr | input | 1 | Local-side write strobe |
| loc_addr | input | 12 | Local-side byte address |
| loc_wdata | input | 32 | Local-side write data |
| loc_rdata | output | 32 | Local-side read data (combinational) |
| rem_wr | input | 1 | Remote-side write strobe |
| rem_addr | input | 12 | Remote-side byte address |
| rem_wdata | input | 32 | Remote-side write data |
| rem_rdata | output | 32 | Remote-side read data (combinational) |
| loc_irq | output | 1 | Interrupt to the local core, active high |
| rem_irq_n | output | 1 | Interrupt request on the remote bus, active low |

## Verification
The bench writes a mailbox and clears the same status bit in the same cycle. A design that gives the clear priority would lose the message notification there.

It also sends writes from the side that does not own a register:
- a local write to an inbound mailbox,
- a remote write-1 to the inbound status,
- a remote write to the inbound mask.

It then reads the affected registers back. A design that does not check which side wrote would show changed data, or a missing status bit.

The bench checks masking in both orders: the mask is set before the message arrives, and it is removed after. A design that latched the interrupt, instead of deriving it from status and mask, would miss the interrupt that appears when the mask is removed. The bench also checks that `rem_irq_n` is active low.

// File: rtl/mbox_pkg.sv
// Package: address map and shared sizes for the mailbox message unit.
// Assumes word-aligned byte addresses on a 12-bit local window.
package mbox_pkg;
    localparam int MBOX_ADDR_W   = 12;
    localparam int MBOX_DATA_W   = 32;
    localparam int MBOX_N_MSG    = 2;
    // Inbound mailboxes start here; outbound ones follow directly.
    localparam int IN_MSG_BASE   = 'h050;
    localparam int OUT_MSG_BASE  = 'h058;
    localparam int IN_STAT_OFF   = 'h060;
    localparam int IN_MASK_OFF   = 'h064;
    localparam int OUT_STAT_OFF  = 'h068;
    localparam int OUT_MASK_OFF  = 'h06C;
endpackage

// File: rtl/mbox_decode.sv
// Module: mbox_decode
// Turns one port's address into hit flags for every register of the map.
// Assumes word-aligned addresses. At most one flag is set for any address.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = MBOX_ADDR_W,
    parameter int N_MSG  = MBOX_N_MSG,
    localparam int IDX_W = (N_MSG > 1) ? $clog2(N_MSG) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_msg_hit,
    output logic [IDX_W-1:0]  in_idx,
    output logic              out_msg_hit,
    output logic [IDX_W-1:0]  out_idx,
    output logic              in_stat_hit,
    output logic              in_mask_hit,
    output logic              out_stat_hit,
    output logic              out_mask_hit
);
    // Compare the address against each mailbox slot of both directions.
    always_comb begin
        in_msg_hit  = 1'b0;
        in_idx      = '0;
        out_msg_hit = 1'b0;
        out_idx     = '0;
        for (int i = 0; i < N_MSG; i++) begin
            if (addr == ADDR_W'(IN_MSG_BASE + 4 * i)) begin
                in_msg_hit = 1'b1;
                in_idx     = IDX_W'(i);
            end
            if (addr == ADDR_W'(OUT_MSG_BASE + 4 * i)) begin
                out_msg_hit = 1'b1;
                out_idx     = IDX_W'(i);
            end
        end
    end

    // Control register hits.
    assign in_stat_hit  = (addr == ADDR_W'(IN_STAT_OFF));
    assign in_mask_hit  = (addr == ADDR_W'(IN_MASK_OFF));
    assign out_stat_hit = (addr == ADDR_W'(OUT_STAT_OFF));
    assign out_mask_hit = (addr == ADDR_W'(OUT_MASK_OFF));

    // R10: decoded hits are mutually exclusive
    always_comb begin
        onehot_hit_chk: assert ($onehot0({in_msg_hit, out_msg_hit, in_stat_hit,
                                          in_mask_hit, out_stat_hit, out_mask_hit}));
    end
endmodule

// File: rtl/mbox_channel.sv
// Module: mbox_channel
// One direction of mailboxes. The producer fills the message words. The
// consumer owns the sticky status bits (clears them with write-1) and the mask.
// Assumes the caller has already applied side ownership to every strobe.
module mbox_channel
    import mbox_pkg::*;
#(
    parameter int DATA_W = MBOX_DATA_W,
    parameter int N_MSG  = MBOX_N_MSG,
    localparam int IDX_W = (N_MSG > 1) ? $clog2(N_MSG) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          prod_wr,
    input  logic [IDX_W-1:0]              prod_idx,
    input  logic [DATA_W-1:0]             prod_data,
    input  logic                          cons_clr,
    input  logic                          cons_mask_wr,
    input  logic [N_MSG-1:0]              cons_bits,
    output logic [N_MSG-1:0][DATA_W-1:0]  msg_q,
    output logic [N_MSG-1:0]              stat_q,
    output logic [N_MSG-1:0]              mask_q,
    output logic                          irq
);
    logic [N_MSG-1:0] set_vec;
    logic [N_MSG-1:0] clr_vec;

    for (genvar g = 0; g < N_MSG; g++) begin : g_slot
        // Flag that this slot is the target of the current producer write.
        assign set_vec[g] = prod_wr && (prod_idx == IDX_W'(g));

        // Message word: no defined reset value, so it is left without reset.
        always_ff @(posedge clk) begin
            if (set_vec[g]) msg_q[g] <= prod_data;
        end
    end

    assign clr_vec = cons_clr ? cons_bits : '0;

    // Sticky status: a set beats a clear that lands in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    // Mask register, owned by the consumer.
    always_ff @(posedge clk) begin
        if (!rst_n)            mask_q <= '0;
        else if (cons_mask_wr) mask_q <= cons_bits;
    end

    // Interrupt request from pending unmasked status.
    assign irq = |(stat_q & ~mask_q);

    // R4, R6
    // msg_sets_status_chk
    msg_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod_wr |=> stat_q[$past(prod_idx)]);

    // R5
    // sticky_hold_chk
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prod_wr && !cons_clr) |=> (stat_q == $past(stat_q)));

    // R5
    // w1c_clears_chk
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_clr && !prod_wr) |=> ((stat_q & $past(cons_bits)) == '0));

    // R7
    // mask_hold_chk
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_mask_wr |=> $stable(mask_q));

    // R8
    // irq_cause_chk
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(prod_wr || cons_mask_wr));
endmodule

// File: rtl/mbox_read_mux.sv
// Module: mbox_read_mux
// Selects the read data for one port from the decoded address.
// Assumes at most one hit flag is set. Unmapped addresses return zero.
module mbox_read_mux
    import mbox_pkg::*;
#(
    parameter int DATA_W = MBOX_DATA_W,
    parameter int N_MSG  = MBOX_N_MSG,
    localparam int IDX_W = (N_MSG > 1) ? $clog2(N_MSG) : 1
) (
    input  logic                          in_msg_hit,
    input  logic [IDX_W-1:0]              in_idx,
    input  logic                          out_msg_hit,
    input  logic [IDX_W-1:0]              out_idx,
    input  logic                          in_stat_hit,
    input  logic                          in_mask_hit,
    input  logic                          out_stat_hit,
    input  logic                          out_mask_hit,
    input  logic [N_MSG-1:0][DATA_W-1:0]  in_msg,
    input  logic [N_MSG-1:0][DATA_W-1:0]  out_msg,
    input  logic [N_MSG-1:0]              in_stat,
    input  logic [N_MSG-1:0]              in_mask,
    input  logic [N_MSG-1:0]              out_stat,
    input  logic [N_MSG-1:0]              out_mask,
    output logic [DATA_W-1:0]             rdata
);
    // Read data selection, zero-extending the narrow control registers.
    always_comb begin
        rdata = '0;
        if (in_msg_hit)        rdata = in_msg[in_idx];
        else if (out_msg_hit)  rdata = out_msg[out_idx];
        else if (in_stat_hit)  rdata = DATA_W'(in_stat);
        else if (in_mask_hit)  rdata = DATA_W'(in_mask);
        else if (out_stat_hit) rdata = DATA_W'(out_stat);
        else if (out_mask_hit) rdata = DATA_W'(out_mask);
    end
endmodule

// File: rtl/mbox_msg_unit.sv
// Module: mbox_msg_unit (top)
// Mailbox registers between a local core and a remote bus master. Inbound
// mailboxes are filled remotely and interrupt the local core. Outbound ones
// are filled locally and pull the active-low remote interrupt.
// Assumes single-cycle write strobes and combinational reads on both ports.
module mbox_msg_unit
    import mbox_pkg::*;
#(
    parameter int ADDR_W = MBOX_ADDR_W,
    parameter int DATA_W = MBOX_DATA_W,
    parameter int N_MSG  = MBOX_N_MSG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_wr,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic              rem_wr,
    input  logic [ADDR_W-1:0] rem_addr,
    input  logic [DATA_W-1:0] rem_wdata,
    output logic [DATA_W-1:0] rem_rdata,
    output logic              loc_irq,
    output logic              rem_irq_n
);
    localparam int IDX_W = (N_MSG > 1) ? $clog2(N_MSG) : 1;

    // Decoded hits, index 0 = local port, index 1 = remote port.
    logic [1:0]             d_in_msg, d_out_msg, d_in_stat, d_in_mask, d_out_stat, d_out_mask;
    logic [1:0][IDX_W-1:0]  d_in_idx, d_out_idx;
    logic [1:0][ADDR_W-1:0] p_addr;
    logic [1:0][DATA_W-1:0] p_rdata;

    logic [N_MSG-1:0][DATA_W-1:0] in_msg, out_msg;
    logic [N_MSG-1:0]             in_stat, in_mask, out_stat, out_mask;
    logic                         in_irq, out_irq;

    assign p_addr[0] = loc_addr;
    assign p_addr[1] = rem_addr;

    // One decoder and one read mux per port.
    for (genvar p = 0; p < 2; p++) begin : g_port
        mbox_decode #(.ADDR_W(ADDR_W), .N_MSG(N_MSG)) u_dec (
            .addr         (p_addr[p]),
            .in_msg_hit   (d_in_msg[p]),
            .in_idx       (d_in_idx[p]),
            .out_msg_hit  (d_out_msg[p]),
            .out_idx      (d_out_idx[p]),
            .in_stat_hit  (d_in_stat[p]),
            .in_mask_hit  (d_in_mask[p]),
            .out_stat_hit (d_out_stat[p]),
            .out_mask_hit (d_out_mask[p])
        );

        mbox_read_mux #(.DATA_W(DATA_W), .N_MSG(N_MSG)) u_rd (
            .in_msg_hit   (d_in_msg[p]),
            .in_idx       (d_in_idx[p]),
            .out_msg_hit  (d_out_msg[p]),
            .out_idx      (d_out_idx[p]),
            .in_stat_hit  (d_in_stat[p]),
            .in_mask_hit  (d_in_mask[p]),
            .out_stat_hit (d_out_stat[p]),
            .out_mask_hit (d_out_mask[p]),
            .in_msg       (in_msg),
            .out_msg      (out_msg),
            .in_stat      (in_stat),
            .in_mask      (in_mask),
            .out_stat     (out_stat),
            .out_mask     (out_mask),
            .rdata        (p_rdata[p])
        );
    end

    assign loc_rdata = p_rdata[0];
    assign rem_rdata = p_rdata[1];

    // Inbound: remote produces, local consumes.
    mbox_channel #(.DATA_W(DATA_W), .N_MSG(N_MSG)) u_inbound (
        .clk          (clk),
        .rst_n        (rst_n),
        .prod_wr      (rem_wr && d_in_msg[1]),
        .prod_idx     (d_in_idx[1]),
        .prod_data    (rem_wdata),
        .cons_clr     (loc_wr && d_in_stat[0]),
        .cons_mask_wr (loc_wr && d_in_mask[0]),
        .cons_bits    (loc_wdata[N_MSG-1:0]),
        .msg_q        (in_msg),
        .stat_q       (in_stat),
        .mask_q       (in_mask),
        .irq          (in_irq)
    );

    // Outbound: local produces, remote consumes.
    mbox_channel #(.DATA_W(DATA_W), .N_MSG(N_MSG)) u_outbound (
        .clk          (clk),
        .rst_n        (rst_n),
        .prod_wr      (loc_wr && d_out_msg[0]),
        .prod_idx     (d_out_idx[0]),
        .prod_data    (loc_wdata),
        .cons_clr     (rem_wr && d_out_stat[1]),
        .cons_mask_wr (rem_wr && d_out_mask[1]),
        .cons_bits    (rem_wdata[N_MSG-1:0]),
        .msg_q        (out_msg),
        .stat_q       (out_stat),
        .mask_q       (out_mask),
        .irq          (out_irq)
    );

    assign loc_irq   = in_irq;
    assign rem_irq_n = ~out_irq;

    // R9
    // local_no_inbound_fill_chk
    local_no_inbound_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rem_wr && d_in_msg[1])) |=> $stable(in_msg));

    // R9
    // remote_no_outbound_fill_chk
    remote_no_outbound_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(loc_wr && d_out_msg[0])) |=> $stable(out_msg));

    // R1
    // reset_quiet_chk
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!loc_irq && rem_irq_n));
endmodule

// File: tb/mbox_msg_unit_tb_top.sv
// Scoreboard bench: check tasks queue expected values, a negedge monitor compares.
module mbox_msg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_wr = 1'b0, rem_wr = 1'b0;
    logic [11:0] loc_addr = '0, rem_addr = '0;
    logic [31:0] loc_wdata = '0, rem_wdata = '0;
    logic [31:0] loc_rdata, rem_rdata;
    logic        loc_irq, rem_irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          kind;   // 0 loc_rdata, 1 rem_rdata, 2 loc_irq, 3 rem_irq_n
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    mbox_msg_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .rem_wr(rem_wr), .rem_addr(rem_addr), .rem_wdata(rem_wdata), .rem_rdata(rem_rdata),
        .loc_irq(loc_irq), .rem_irq_n(rem_irq_n)
    );

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t        it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = loc_rdata;
                1:       act = rem_rdata;
                2:       act = {31'b0, loc_irq};
                default: act = {31'b0, rem_irq_n};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // One-cycle write pulse from one side (0 local, 1 remote).
    task automatic wr(input int side, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        if (side == 0) begin loc_wr = 1; loc_addr = a; loc_wdata = d; end
        else           begin rem_wr = 1; rem_addr = a; rem_wdata = d; end
        @(posedge clk); #1;
        loc_wr = 0; rem_wr = 0;
    endtask

    // Remote mailbox write and local status clear in the same cycle.
    task automatic wr_both(input logic [11:0] la, input logic [31:0] ld,
                           input logic [11:0] ra, input logic [31:0] rd);
        @(posedge clk); #1;
        loc_wr = 1; loc_addr = la; loc_wdata = ld;
        rem_wr = 1; rem_addr = ra; rem_wdata = rd;
        @(posedge clk); #1;
        loc_wr = 0; rem_wr = 0;
    endtask

    // Queue an expected read or interrupt level; the monitor compares it.
    task automatic chk(input int kind, input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        if (kind == 0) loc_addr = a;
        if (kind == 1) rem_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(0, 12'h060, 0, "R1 in status");
        chk(0, 12'h064, 0, "R1 in mask");
        chk(1, 12'h068, 0, "R1 out status");
        chk(1, 12'h06C, 0, "R1 out mask");
        chk(2, 0, 0, "R1 loc_irq");
        chk(3, 0, 1, "R1 rem_irq_n");
        // R2 inbound fill, R4 status, R8 irq
        wr(1, 12'h050, 32'hA5A5_0001);
        chk(0, 12'h050, 32'hA5A5_0001, "R2 local read in0");
        chk(1, 12'h050, 32'hA5A5_0001, "R2 remote read in0");
        chk(0, 12'h060, 1, "R4 in status bit0");
        chk(2, 0, 1, "R8 loc_irq set");
        chk(3, 0, 1, "R8 rem_irq_n idle");
        // R5: write-0 keeps, write-1 clears
        wr(0, 12'h060, 32'h0000_0002);
        chk(0, 12'h060, 1, "R5 write-0 keeps bit0");
        wr(0, 12'h060, 32'h0000_0001);
        chk(0, 12'h060, 0, "R5 w1c clears");
        chk(2, 0, 0, "R8 loc_irq after clear");
        // R7 masked arrival then unmask
        wr(0, 12'h064, 32'h2);
        wr(1, 12'h054, 32'h1234_5678);
        chk(0, 12'h054, 32'h1234_5678, "R2 read in1");
        chk(0, 12'h060, 2, "R4 in status bit1");
        chk(2, 0, 0, "R7 masked loc_irq");
        wr(0, 12'h064, 32'h0);
        chk(2, 0, 1, "R8 unmask raises loc_irq");
        wr(0, 12'h060, 32'h2);
        chk(2, 0, 0, "R5 loc_irq dropped");
        // R3 outbound fill, R8 active-low
        wr(0, 12'h05C, 32'hDEAD_BEEF);
        chk(1, 12'h05C, 32'hDEAD_BEEF, "R3 remote read out1");
        chk(0, 12'h05C, 32'hDEAD_BEEF, "R3 local read out1");
        chk(1, 12'h068, 2, "R4 out status bit1");
        chk(3, 0, 0, "R8 rem_irq_n low");
        wr(1, 12'h068, 32'h2);
        chk(3, 0, 1, "R5 rem_irq_n released");
        // R7 outbound mask by remote
        wr(1, 12'h06C, 32'h1);
        wr(0, 12'h058, 32'h0000_00C3);
        chk(1, 12'h068, 1, "R4 out status bit0");
        chk(3, 0, 1, "R7 masked rem_irq_n");
        wr(1, 12'h06C, 32'h0);
        chk(3, 0, 0, "R8 unmask lowers rem_irq_n");
        wr(1, 12'h068, 32'h1);
        // R9 wrong-side writes
        wr(0, 12'h050, 32'hFFFF_FFFF);
        chk(0, 12'h050, 32'hA5A5_0001, "R9 local write to inbound ignored");
        chk(0, 12'h060, 0, "R9 no status from ignored write");
        wr(1, 12'h05C, 32'h0);
        chk(1, 12'h05C, 32'hDEAD_BEEF, "R9 remote write to outbound ignored");
        wr(1, 12'h050, 32'h0000_0055);
        wr(1, 12'h060, 32'h1);
        chk(0, 12'h060, 1, "R9 remote clear of in status ignored");
        wr(1, 12'h064, 32'h3);
        chk(0, 12'h064, 0, "R9 remote mask write ignored");
        wr(0, 12'h06C, 32'h3);
        chk(1, 12'h06C, 0, "R9 local out-mask write ignored");
        // R6 set beats clear
        wr_both(12'h060, 32'h1, 12'h050, 32'h0000_0077);
        chk(0, 12'h060, 1, "R6 set wins over clear");
        chk(0, 12'h050, 32'h0000_0077, "R6 data stored");
        // R10 unmapped
        chk(0, 12'h070, 0, "R10 unmapped local");
        chk(1, 12'h000, 0, "R10 unmapped remote");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule